// File: doc/BRIEF.md
# Decoded RAM/ROM Byte Memory Subsystem

This block is a byte-wide memory on a 10-bit address bus. The upper half of the space is one 512-byte read-only array. The lower half is split across four 128-byte RAM banks. An address decoder looks at the upper address lines and drives a two-line enable pair into every storage chip. A chip answers only when the positive enable line is high and the negative one is low.

A host drives an address, a write byte and two strobes, read and write, and gets a read byte back in the same cycle. Writes land on the rising clock edge. The read-only contents are set when the block is elaborated, through a wide parameter.

The interface is a plain strobe interface with no back-pressure. The block accepts a request on every cycle and never stalls. A valid/ready handshake would therefore always show ready, so the block does not have one.

Top module: `memsys_top`

## Requirements
- R1: Address bit 9 set to 1 selects the read-only array, and the array is indexed by address bits 8..0, so addresses 0x200 to 0x3FF map to image bytes 0 to 511.
- R2: With address bit 9 at 0, address bits 8..7 select one RAM bank and bits 6..0 give the offset in it. Code 00 covers 0x000-0x07F, 01 covers 0x080-0x0FF, 10 covers 0x100-0x17F and 11 covers 0x180-0x1FF. At most one chip is enabled at any time.
- R3: A read of the read-only region returns byte k of the elaboration image, where k is the low 9 address bits, and keeps returning it while the address and the read strobe are held.
- R4: A write strobe aimed at the read-only region changes no stored byte. This applies to the RAM byte that shares the same low 9 bits as well.
- R5: With the write strobe at 1 and the read strobe at 0 in the RAM region, the write byte is stored on the rising clock edge. A later read returns it, and the other banks keep their own contents.
- R6: While the read strobe is 0, the read data is 0x00.
- R7: While the active-low reset is held, every RAM byte is cleared to 0x00.
- R8: Read and write strobes together are outside legal use. In that case the write is suppressed and the read returns the byte stored before that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the RAM |
| addr | input | 10 | Byte address |
| wdata | input | 8 | Byte to write |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| rdata | output | 8 | Combinational read byte; 0x00 when nothing is read |

## Verification
The checker does not assume that the two strobes are exclusive. Instead it requires the decoder to hold back the write gate whenever both strobes are high, so the bench may drive overlapping strobes on purpose and still keep every property intact. The stability property for the read-only region assumes the image is fixed at elaboration, and the stimulus never changes that parameter during a run. The random phase draws addresses over the whole 10-bit space and strobe combinations freely. A behavioural byte array in the bench tracks every legal write and predicts each read byte.

// File: rtl/memsys_pkg.sv
package memsys_pkg;

  localparam int unsigned DEF_DATA_W    = 8;
  localparam int unsigned DEF_ADDR_W    = 10;
  localparam int unsigned DEF_RAM_BANKS = 4;
  localparam int unsigned DEF_ROM_BYTES = 2 ** (DEF_ADDR_W - 1);

  // Two-line enable pair carried to every storage chip.
  typedef struct packed {
    logic sel_pos;    // active high
    logic sel_neg_n;  // active low
  } chip_sel_t;

  function automatic logic chip_enabled(input chip_sel_t s);
    return s.sel_pos & ~s.sel_neg_n;
  endfunction

  // Default read-only image: computed, not tabulated.
  function automatic logic [DEF_ROM_BYTES*DEF_DATA_W-1:0] default_rom_image();
    logic [DEF_ROM_BYTES*DEF_DATA_W-1:0] img;
    img = '0;
    for (int i = 0; i < int'(DEF_ROM_BYTES); i++) begin
      img[i*DEF_DATA_W +: DEF_DATA_W] = DEF_DATA_W'(i) ^ 8'hA5;
    end
    return img;
  endfunction

endpackage

// File: rtl/memsys_decode.sv
module memsys_decode
  import memsys_pkg::*;
#(
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned RAM_BANKS = DEF_RAM_BANKS
) (
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           rd,
  input  logic                           wr,
  output chip_sel_t [RAM_BANKS-1:0]      ram_cs,
  output chip_sel_t                      rom_cs,
  output logic                           wr_gate
);

  localparam int unsigned BSEL_W = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1;
  localparam int unsigned ROM_BIT = ADDR_W - 1;

  logic              rom_term;
  logic [BSEL_W-1:0] bank_idx;

  assign rom_term = addr[ROM_BIT];
  assign bank_idx = addr[ROM_BIT-1 -: BSEL_W];

  assign rom_cs.sel_pos   = rom_term;
  assign rom_cs.sel_neg_n = 1'b0;

  generate
    for (genvar b = 0; b < int'(RAM_BANKS); b++) begin : g_bank_sel
      assign ram_cs[b].sel_pos   = ~rom_term & (bank_idx == BSEL_W'(b));
      assign ram_cs[b].sel_neg_n = 1'b0;
    end
  endgenerate

  // Overlapping strobes: the read wins, the write is held back.
  assign wr_gate = wr & ~rd;

endmodule

// File: rtl/memsys_ram_bank.sv
module memsys_ram_bank
  import memsys_pkg::*;
#(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned DATA_W = DEF_DATA_W,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  chip_sel_t         cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              en;

  assign en = chip_enabled(cs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else if (en && wr) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = (en && rd) ? mem[addr] : '0;

endmodule

// File: rtl/memsys_rom_bank.sv
module memsys_rom_bank
  import memsys_pkg::*;
#(
  parameter int unsigned DEPTH  = DEF_ROM_BYTES,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter logic [DEPTH*DATA_W-1:0] IMAGE = '0,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  chip_sel_t         cs,
  input  logic              rd,
  input  logic [AW-1:0]     addr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] word;

  assign word  = IMAGE[int'(addr)*DATA_W +: DATA_W];
  assign rdata = (chip_enabled(cs) && rd) ? word : '0;

endmodule

// File: rtl/memsys_top.sv
module memsys_top
  import memsys_pkg::*;
#(
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned RAM_BANKS = DEF_RAM_BANKS,
  parameter logic [(2**(ADDR_W-1))*DATA_W-1:0] ROM_IMAGE = default_rom_image()
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  input  logic              wr,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned ROM_BYTES = 2 ** (ADDR_W - 1);
  localparam int unsigned RAM_DEPTH = ROM_BYTES / RAM_BANKS;
  localparam int unsigned RAM_AW    = $clog2(RAM_DEPTH);
  localparam int unsigned ROM_AW    = ADDR_W - 1;

  chip_sel_t [RAM_BANKS-1:0] ram_cs;
  chip_sel_t                 rom_cs;
  logic                      wr_gate;
  logic [DATA_W-1:0]         bank_rd [RAM_BANKS];
  logic [DATA_W-1:0]         rom_rd;

  memsys_decode #(
    .ADDR_W    (ADDR_W),
    .RAM_BANKS (RAM_BANKS)
  ) i_decode (
    .addr    (addr),
    .rd      (rd),
    .wr      (wr),
    .ram_cs  (ram_cs),
    .rom_cs  (rom_cs),
    .wr_gate (wr_gate)
  );

  generate
    for (genvar b = 0; b < int'(RAM_BANKS); b++) begin : g_ram
      memsys_ram_bank #(
        .DEPTH  (RAM_DEPTH),
        .DATA_W (DATA_W)
      ) i_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .cs    (ram_cs[b]),
        .rd    (rd),
        .wr    (wr_gate),
        .addr  (addr[RAM_AW-1:0]),
        .wdata (wdata),
        .rdata (bank_rd[b])
      );
    end
  endgenerate

  memsys_rom_bank #(
    .DEPTH  (ROM_BYTES),
    .DATA_W (DATA_W),
    .IMAGE  (ROM_IMAGE)
  ) i_rom (
    .cs    (rom_cs),
    .rd    (rd),
    .addr  (addr[ROM_AW-1:0]),
    .rdata (rom_rd)
  );

  // Disabled chips drive zero, so an OR merges the read paths.
  always_comb begin
    rdata = rom_rd;
    for (int b = 0; b < int'(RAM_BANKS); b++) rdata = rdata | bank_rd[b];
  end

endmodule

// File: rtl/memsys_checker.sv
module memsys_checker
  import memsys_pkg::*;
#(
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned RAM_BANKS = DEF_RAM_BANKS
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [ADDR_W-1:0]         addr,
  input logic                      rd,
  input logic                      wr,
  input logic [DATA_W-1:0]         rdata,
  input chip_sel_t [RAM_BANKS-1:0] ram_cs,
  input chip_sel_t                 rom_cs,
  input logic                      wr_gate
);

  logic [RAM_BANKS-1:0] ram_en;
  logic                 rom_en;

  always_comb begin
    for (int b = 0; b < int'(RAM_BANKS); b++) ram_en[b] = chip_enabled(ram_cs[b]);
    rom_en = chip_enabled(rom_cs);
  end

  AST_SINGLE_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_en, ram_en})); // R2

  AST_UPPER_HALF_IS_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    addr[ADDR_W-1] |-> (rom_en && ram_en == '0)); // R1

  AST_ROM_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr[ADDR_W-1]) |-> (ram_en == '0)); // R4

  AST_OVERLAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && wr) |-> !wr_gate); // R8

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (rdata == '0)); // R6

  AST_ROM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr[ADDR_W-1] && $past(rd) && $stable(addr)) |-> $stable(rdata)); // R3

endmodule

bind memsys_top memsys_checker #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .RAM_BANKS (RAM_BANKS)
) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .rd      (rd),
  .wr      (wr),
  .rdata   (rdata),
  .ram_cs  (ram_cs),
  .rom_cs  (rom_cs),
  .wr_gate (wr_gate)
);

// File: tb/test_memsys_top.sv
module test_memsys_top;

  localparam int AW    = 10;
  localparam int DW    = 8;
  localparam int ROM_N = 512;

  function automatic logic [7:0] rom_byte(input int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  function automatic logic [ROM_N*DW-1:0] make_image();
    logic [ROM_N*DW-1:0] img;
    img = '0;
    for (int i = 0; i < ROM_N; i++) img[i*DW +: DW] = rom_byte(i);
    return img;
  endfunction

  localparam logic [ROM_N*DW-1:0] IMG = make_image();

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic          rd;
  logic          wr;
  logic [DW-1:0] rdata;

  int unsigned tests = 0;
  int unsigned fails = 0;
  logic [7:0]  model [ROM_N];

  always #5 clk = ~clk;

  memsys_top #(.ROM_IMAGE(IMG)) i_memsys_top (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wdata (wdata),
    .rd    (rd),
    .wr    (wr),
    .rdata (rdata)
  );

  function automatic logic [7:0] predict(input logic [AW-1:0] a, input logic r);
    if (!r) return 8'h00;
    if (a[9]) return rom_byte(int'(a[8:0]));
    return model[a[8:0]];
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp,
                       input logic [AW-1:0] a);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%03h actual=%02h expected=%02h", tag, a, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, compare before the rising edge, then update the model.
  task automatic step(input logic [AW-1:0] a, input logic [7:0] d, input logic r,
                      input logic w, input string tag);
    @(negedge clk);
    addr = a; wdata = d; rd = r; wr = w;
    #1;
    check(tag, rdata, predict(a, r), a);
    @(posedge clk);
    if (w && !r && !a[9]) model[a[8:0]] = d;
  endtask

  function automatic string pick_tag(input logic [AW-1:0] a, input logic r, input logic w);
    if (!r) return "R6";
    if (w) return "R8";
    if (a[9]) return "R3";
    return "R5";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < ROM_N; i++) model[i] = 8'h00;
    rst_n = 1'b0; addr = '0; wdata = '0; rd = 1'b0; wr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R7: RAM clear after reset, at bank edges
    step(10'h000, 8'h00, 1'b1, 1'b0, "R7");
    step(10'h07F, 8'h00, 1'b1, 1'b0, "R7");
    step(10'h080, 8'h00, 1'b1, 1'b0, "R7");
    step(10'h1FF, 8'h00, 1'b1, 1'b0, "R7");

    // R6: idle read is zero, even on the ROM
    step(10'h2A0, 8'h00, 1'b0, 1'b0, "R6");

    // R1 / R3: ROM reads, held read and strided sweep
    step(10'h200, 8'h00, 1'b1, 1'b0, "R1");
    step(10'h3FF, 8'h00, 1'b1, 1'b0, "R1");
    step(10'h3FF, 8'h00, 1'b1, 1'b0, "R3");
    for (int k = 0; k < 32; k++) step(AW'(10'h200 + k * 13), 8'h00, 1'b1, 1'b0, "R3");

    // R2 / R5: same offset in every bank, then bank edges
    step(10'h005, 8'h11, 1'b0, 1'b1, "R5");
    step(10'h085, 8'h22, 1'b0, 1'b1, "R5");
    step(10'h105, 8'h33, 1'b0, 1'b1, "R5");
    step(10'h185, 8'h44, 1'b0, 1'b1, "R5");
    step(10'h005, 8'h00, 1'b1, 1'b0, "R2");
    step(10'h085, 8'h00, 1'b1, 1'b0, "R2");
    step(10'h105, 8'h00, 1'b1, 1'b0, "R2");
    step(10'h185, 8'h00, 1'b1, 1'b0, "R2");
    step(10'h07F, 8'hC1, 1'b0, 1'b1, "R5");
    step(10'h080, 8'hC2, 1'b0, 1'b1, "R5");
    step(10'h07F, 8'h00, 1'b1, 1'b0, "R2");
    step(10'h080, 8'h00, 1'b1, 1'b0, "R2");

    // R4: write to ROM region, aliased RAM byte untouched
    step(10'h0AA, 8'h5C, 1'b0, 1'b1, "R5");
    step(10'h2AA, 8'hFF, 1'b0, 1'b1, "R4");
    step(10'h2AA, 8'h00, 1'b1, 1'b0, "R4");
    step(10'h0AA, 8'h00, 1'b1, 1'b0, "R4");

    // R8: overlapping strobes suppress the write
    step(10'h010, 8'h5A, 1'b1, 1'b1, "R8");
    step(10'h010, 8'h00, 1'b1, 1'b0, "R8");

    // R6: write with read low returns zero yet stores
    step(10'h011, 8'h9D, 1'b0, 1'b1, "R6");
    step(10'h011, 8'h00, 1'b1, 1'b0, "R5");

    // Random traffic over the whole space
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a;
      logic r, w;
      a = AW'($urandom);
      r = 1'($urandom);
      w = 1'($urandom);
      step(a, 8'($urandom), r, w, pick_tag(a, r, w));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule